// File: doc/BRIEF.md
# Row-Group High-Momentum Track Filter

This block watches a strip of detector rows, one bit per row per bunch crossing (BX), and picks out straight, high-momentum tracks. A straight track lights a single row for the whole drift time. A curved track spreads its charge across many rows. For each row the block forms a sliding frame: the OR of that row and the next rows up to the frame size. It counts, over a window of recent BX, in how many of them the frame was active. When that count first reaches the threshold, the row has a detection. The block tags the detection with the BX number of the oldest active BX in the window, which is when the track first appeared.

One track lights several overlapping frames, so the block thins the detections. A row's detection is dropped when a nearby row detected at the same time or shortly before. Only one report per track survives. Survivors wait in a one-entry slot per row. A two-state drain machine (`S_IDLE`, `S_DRAIN`) takes a snapshot of all waiting rows and copies them one per clock, lowest row first, into an output FIFO. The FIFO is read with a valid/pop pair. Records that cannot be stored are dropped and raise a sticky overflow flag.

Drain machine transitions:
- `S_IDLE` goes to `S_DRAIN` when any row slot is pending. The pending set is loaded as the batch.
- `S_DRAIN` emits the lowest row of the batch each clock. It returns to `S_IDLE` once the batch is empty.

Top module: `rtf_row_trigger`

## Requirements
- R1: The frame of row r is the OR of input rows r to r+FRAME_ROWS-1 (default 8). Rows past N_ROWS-1 read as zero. With the defaults, a track on row 3 is reported as row 0, and a track on row 127 is reported as row 120.
- R2: A row detects when the number of active-frame BX among the last WIN_BX (8) goes from below THRESH (7) to THRESH or more. Continued activity at or above THRESH gives no new detection, and 6 active BX give none at all.
- R3: The reported BXID is the `bxid_i` value of the oldest active BX in the frame window at the moment of detection. This holds even when the window has a gap.
- R4: A detection on row r is discarded if any row r-7 to r-1 detected in the same BX or in any of the 3 preceding BX. With default VETO_BX of 4, a lower-row detection 4 BX earlier does not veto.
- R5: A detection on row r is discarded if any row r+1 to r+7 detected in any of the 3 preceding BX.
- R6: Surviving detections from the same BX are delivered in ascending row order. Every surviving detection is delivered exactly once.
- R7: `rd_valid_o` is high while the FIFO holds a record. `rd_row_o` and `rd_bxid_o` show the oldest record, and `rd_en_i` with `rd_valid_o` high removes it.
- R8: A record that meets a full FIFO, or that meets a row slot still occupied, is dropped. `overflow_o` then goes high and stays high until reset. Records already stored are kept.
- R9: During and after reset, `rd_valid_o` and `overflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | BX clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_rows_i | input | N_ROWS | Per-row hit bits for the current BX |
| bxid_i | input | BXID_W | BX number of the current BX |
| rd_en_i | input | 1 | Pop the head record |
| rd_valid_o | output | 1 | FIFO holds at least one record |
| rd_row_o | output | ROW_W | Row ID of the head record |
| rd_bxid_o | output | BXID_W | First-hit BXID of the head record |
| overflow_o | output | 1 | Sticky flag for a lost record |

## Verification
The bench keeps the default 128 rows, frame of 8, window of 8, threshold of 7 and veto reach of 7 rows over 4 BX, so both array edges are reached. It shrinks FIFO_DEPTH to 4, so five widely spaced tracks in one BX fill the queue and the fifth record is lost. It also sets BXID_W to 8 for compact expected values. Staggering two tracks by 3 and then by 4 BX lands detections on both sides of the veto time limit.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_DRAIN = 1'b1
    } drain_state_e;
endpackage

// File: rtl/rtf_time_filter.sv
// Per-row sliding frame, BX window and threshold crossing detector.
module rtf_time_filter #(
    parameter int N_ROWS     = 128,
    parameter int FRAME_ROWS = 8,
    parameter int WIN_BX     = 8,
    parameter int THRESH     = 7,
    parameter int IDX_W      = $clog2(WIN_BX)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_ROWS-1:0]        hit_rows_i,
    output logic [N_ROWS-1:0]        det_o,
    output logic [N_ROWS*IDX_W-1:0]  oldest_o
);
    localparam int PAD_W = N_ROWS + FRAME_ROWS - 1;

    logic [PAD_W-1:0] padded;
    assign padded = {{(FRAME_ROWS-1){1'b0}}, hit_rows_i};

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        logic              frame;
        logic [WIN_BX-1:0] win_q, win_d;
        logic              above_q, above_d;
        logic              det_q;
        logic [IDX_W-1:0]  idx_q, idx_d;

        assign frame = |padded[r +: FRAME_ROWS];

        always_comb begin
            win_d   = {win_q[WIN_BX-2:0], frame};
            above_d = ($countones(win_d) >= THRESH);
            idx_d   = '0;
            for (int i = 0; i < WIN_BX; i++) begin
                if (win_d[i]) idx_d = IDX_W'(i);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q   <= '0;
                above_q <= 1'b0;
                det_q   <= 1'b0;
                idx_q   <= '0;
            end else begin
                win_q   <= win_d;
                above_q <= above_d;
                det_q   <= above_d & ~above_q;
                idx_q   <= idx_d;
            end
        end

        assign det_o[r]                   = det_q;
        assign oldest_o[r*IDX_W +: IDX_W] = idx_q;
    end
endmodule

// File: rtl/rtf_veto.sv
// Redundancy suppression: lower rows win ties, earlier detections win over later ones.
module rtf_veto #(
    parameter int N_ROWS    = 128,
    parameter int VETO_SPAN = 7,
    parameter int VETO_BX   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ROWS-1:0] det_i,
    output logic [N_ROWS-1:0] surv_o
);
    localparam int HIST  = VETO_BX - 1;
    localparam int PAD_W = N_ROWS + 2 * VETO_SPAN;

    logic [N_ROWS-1:0] hist_q [HIST];
    logic [N_ROWS-1:0] recent;
    logic [PAD_W-1:0]  pad_now, pad_old;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < HIST; k++) hist_q[k] <= '0;
        end else begin
            hist_q[0] <= det_i;
            for (int k = 1; k < HIST; k++) hist_q[k] <= hist_q[k-1];
        end
    end

    always_comb begin
        recent = '0;
        for (int k = 0; k < HIST; k++) recent = recent | hist_q[k];
    end

    assign pad_now = {{VETO_SPAN{1'b0}}, det_i,  {VETO_SPAN{1'b0}}};
    assign pad_old = {{VETO_SPAN{1'b0}}, recent, {VETO_SPAN{1'b0}}};

    for (genvar r = 0; r < N_ROWS; r++) begin : g_keep
        logic below_now, below_old, above_old;
        assign below_now = |pad_now[r +: VETO_SPAN];
        assign below_old = |pad_old[r +: VETO_SPAN];
        assign above_old = |pad_old[r + VETO_SPAN + 1 +: VETO_SPAN];
        assign surv_o[r] = det_i[r] & ~below_now & ~below_old & ~above_old;
    end
endmodule

// File: rtl/rtf_serializer.sv
// Per-row one-entry slots drained in ascending row order, one batch at a time.
module rtf_serializer
    import rtf_pkg::*;
#(
    parameter int N_ROWS = 128,
    parameter int BXID_W = 12,
    parameter int ROW_W  = $clog2(N_ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_ROWS-1:0]          surv_i,
    input  logic [N_ROWS*BXID_W-1:0]   cand_bxid_i,
    output logic                       emit_v_o,
    output logic [ROW_W-1:0]           emit_row_o,
    output logic [BXID_W-1:0]          emit_bxid_o,
    output logic                       lost_o,
    output drain_state_e               state_o,
    output logic                       pend_any_o
);
    drain_state_e       state_q, state_d;
    logic [N_ROWS-1:0]  pend_q, pend_d;
    logic [N_ROWS-1:0]  batch_q, batch_d;
    logic [N_ROWS-1:0]  clr, held, accept;
    logic [ROW_W-1:0]   sel;
    logic [BXID_W-1:0]  slot_bx_q [N_ROWS];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            batch_q <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            batch_q <= batch_d;
            pend_q  <= pend_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < N_ROWS; r++) begin
            if (!rst_n)         slot_bx_q[r] <= '0;
            else if (accept[r]) slot_bx_q[r] <= cand_bxid_i[r*BXID_W +: BXID_W];
        end
    end

    // lowest row of the batch
    always_comb begin
        sel = '0;
        for (int r = N_ROWS - 1; r >= 0; r--) begin
            if (batch_q[r]) sel = ROW_W'(r);
        end
    end

    // outputs
    always_comb begin
        emit_v_o    = (state_q == S_DRAIN) && (|batch_q);
        emit_row_o  = sel;
        emit_bxid_o = slot_bx_q[sel];
        clr         = emit_v_o ? ({{(N_ROWS-1){1'b0}}, 1'b1} << sel) : '0;
        held        = pend_q & ~clr;
        accept      = surv_i & ~held;
        lost_o      = |(surv_i & held);
        pend_d      = held | accept;
        state_o     = state_q;
        pend_any_o  = |pend_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        batch_d = batch_q;
        unique case (state_q)
            S_IDLE: begin
                if (|pend_q) begin
                    batch_d = pend_q;
                    state_d = S_DRAIN;
                end
            end
            S_DRAIN: begin
                batch_d = batch_q & ~clr;
                if (batch_d == '0) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end
endmodule

// File: rtl/rtf_fifo.sv
// Show-ahead synchronous FIFO.
module rtf_fifo #(
    parameter int WIDTH = 19,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [AW:0]      cnt_q;
    logic             wr_ok, rd_ok;

    assign empty_o   = (cnt_q == '0);
    assign full_o    = (cnt_q == (AW+1)'(DEPTH));
    assign wr_ok     = wr_en_i & ~full_o;
    assign rd_ok     = rd_en_i & ~empty_o;
    assign rd_data_o = mem[rp_q];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp_q] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ok) wp_q <= wp_q + 1'b1;
            if (rd_ok) rp_q <= rp_q + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/rtf_row_trigger.sv
// Top: frame/window filter, veto, drain machine and output FIFO.
module rtf_row_trigger
    import rtf_pkg::*;
#(
    parameter int N_ROWS     = 128,
    parameter int FRAME_ROWS = 8,
    parameter int WIN_BX     = 8,
    parameter int THRESH     = 7,
    parameter int VETO_SPAN  = 7,
    parameter int VETO_BX    = 4,
    parameter int BXID_W     = 12,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_ROWS-1:0]         hit_rows_i,
    input  logic [BXID_W-1:0]         bxid_i,
    input  logic                      rd_en_i,
    output logic                      rd_valid_o,
    output logic [$clog2(N_ROWS)-1:0] rd_row_o,
    output logic [BXID_W-1:0]         rd_bxid_o,
    output logic                      overflow_o
);
    localparam int ROW_W = $clog2(N_ROWS);
    localparam int IDX_W = $clog2(WIN_BX);
    localparam int REC_W = ROW_W + BXID_W;

    logic [BXID_W-1:0]        bx_hist_q [WIN_BX];
    logic [N_ROWS-1:0]        det;
    logic [N_ROWS*IDX_W-1:0]  oldest;
    logic [N_ROWS*BXID_W-1:0] cand_bxid;
    logic [N_ROWS-1:0]        surv;
    logic                     emit_v, lost, pend_any;
    logic [ROW_W-1:0]         emit_row;
    logic [BXID_W-1:0]        emit_bxid;
    drain_state_e             state;
    logic [REC_W-1:0]         head;
    logic                     fifo_empty, fifo_full;
    logic                     ovf_q;

    // BXID pipeline aligned with each row's frame window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_BX; i++) bx_hist_q[i] <= '0;
        end else begin
            bx_hist_q[0] <= bxid_i;
            for (int i = 1; i < WIN_BX; i++) bx_hist_q[i] <= bx_hist_q[i-1];
        end
    end

    rtf_time_filter #(
        .N_ROWS(N_ROWS), .FRAME_ROWS(FRAME_ROWS), .WIN_BX(WIN_BX),
        .THRESH(THRESH), .IDX_W(IDX_W)
    ) u_filter (
        .clk(clk), .rst_n(rst_n), .hit_rows_i(hit_rows_i),
        .det_o(det), .oldest_o(oldest)
    );

    always_comb begin
        for (int r = 0; r < N_ROWS; r++) begin
            cand_bxid[r*BXID_W +: BXID_W] = bx_hist_q[oldest[r*IDX_W +: IDX_W]];
        end
    end

    rtf_veto #(
        .N_ROWS(N_ROWS), .VETO_SPAN(VETO_SPAN), .VETO_BX(VETO_BX)
    ) u_veto (
        .clk(clk), .rst_n(rst_n), .det_i(det), .surv_o(surv)
    );

    rtf_serializer #(
        .N_ROWS(N_ROWS), .BXID_W(BXID_W), .ROW_W(ROW_W)
    ) u_ser (
        .clk(clk), .rst_n(rst_n), .surv_i(surv), .cand_bxid_i(cand_bxid),
        .emit_v_o(emit_v), .emit_row_o(emit_row), .emit_bxid_o(emit_bxid),
        .lost_o(lost), .state_o(state), .pend_any_o(pend_any)
    );

    rtf_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(emit_v), .wr_data_i({emit_row, emit_bxid}),
        .rd_en_i(rd_en_i), .rd_data_o(head),
        .empty_o(fifo_empty), .full_o(fifo_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_q | lost | (emit_v & fifo_full);
    end

    assign rd_valid_o = ~fifo_empty;
    assign rd_row_o   = head[REC_W-1 -: ROW_W];
    assign rd_bxid_o  = head[BXID_W-1:0];
    assign overflow_o = ovf_q;
endmodule

// File: rtl/rtf_row_trigger_chk.sv
module rtf_row_trigger_chk
    import rtf_pkg::*;
#(
    parameter int N_ROWS    = 128,
    parameter int VETO_SPAN = 7,
    parameter int ROW_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              rd_valid_o,
    input  logic              overflow_o,
    input  logic [N_ROWS-1:0] surv,
    input  logic              emit_v,
    input  logic [ROW_W-1:0]  emit_row,
    input  drain_state_e      state,
    input  logic              pend_any
);
    function automatic logic spaced(input logic [N_ROWS-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int r = 0; r < N_ROWS; r++) begin
            for (int k = 1; k <= VETO_SPAN; k++) begin
                if (v[r] && (r + k < N_ROWS) && v[r+k]) ok = 1'b0;
            end
        end
        return ok;
    endfunction

    p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    p_valid_falls_on_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid_o) |-> $past(rd_en_i));

    p_survivor_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spaced(surv));

    p_ascending_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_v && $past(emit_v)) |-> (emit_row > $past(emit_row)));

    p_pending_starts_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && pend_any) |=> (state == S_DRAIN));
endmodule

bind rtf_row_trigger rtf_row_trigger_chk #(
    .N_ROWS(N_ROWS), .VETO_SPAN(VETO_SPAN), .ROW_W(ROW_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o),
    .overflow_o(overflow_o), .surv(surv), .emit_v(emit_v),
    .emit_row(emit_row), .state(state), .pend_any(pend_any)
);

// File: tb/tb_rtf_row_trigger.sv
module tb_rtf_row_trigger;
    localparam int N  = 128;
    localparam int BW = 8;
    localparam int RW = 7;
    localparam int FD = 4;
    localparam int PL = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hit_rows = '0;
    logic [BW-1:0] bxid = '0;
    logic          rd_en = 1'b0;
    logic          rd_valid, overflow;
    logic [RW-1:0] rd_row;
    logic [BW-1:0] rd_bxid;

    always #4 clk = ~clk;

    rtf_row_trigger #(.N_ROWS(N), .BXID_W(BW), .FIFO_DEPTH(FD)) dut (
        .clk(clk), .rst_n(rst_n), .hit_rows_i(hit_rows), .bxid_i(bxid),
        .rd_en_i(rd_en), .rd_valid_o(rd_valid), .rd_row_o(rd_row),
        .rd_bxid_o(rd_bxid), .overflow_o(overflow)
    );

    int               checks = 0;
    int               fails = 0;
    bit               drain_en = 1'b1;
    bit               done = 1'b0;
    string            cur_req = "R9";
    logic [RW+BW-1:0] exp_q [$];
    logic [BW-1:0]    bx_cnt = '0;
    logic [N-1:0]     pat [PL];

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_pat();
        for (int i = 0; i < PL; i++) pat[i] = '0;
    endtask

    task automatic add_track(input int row, input int start, input int len);
        for (int i = start; i < start + len; i++) pat[i][row] = 1'b1;
    endtask

    task automatic push_exp(input int row, input logic [BW-1:0] bx);
        exp_q.push_back({RW'(row), bx});
    endtask

    task automatic play(input int quiet);
        for (int i = 0; i < PL; i++) begin
            @(negedge clk);
            hit_rows = pat[i];
            bxid = bx_cnt;
            bx_cnt = bx_cnt + 1'b1;
        end
        for (int i = 0; i < quiet; i++) begin
            @(negedge clk);
            hit_rows = '0;
            bxid = bx_cnt;
            bx_cnt = bx_cnt + 1'b1;
        end
    endtask

    task automatic scenario_end();
        check(exp_q.size() == 0, {cur_req, " records missing"}, exp_q.size(), 0);
    endtask

    // monitor: pops expected records as the design presents them
    always @(negedge clk) begin
        logic [RW+BW-1:0] e;
        if (rst_n && drain_en && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_req, " R6 unexpected record row"}, int'(rd_row), -1);
            end else begin
                e = exp_q.pop_front();
                check(rd_row == e[RW+BW-1:BW], {cur_req, " row"}, int'(rd_row), int'(e[RW+BW-1:BW]));
                check(rd_bxid == e[BW-1:0], {cur_req, " R3 bxid"}, int'(rd_bxid), int'(e[BW-1:0]));
            end
            rd_en = 1'b1;
        end else begin
            rd_en = 1'b0;
        end
    end

    initial begin
        logic [BW-1:0] b;
        repeat (5) @(negedge clk);
        // R9: reset state
        check(rd_valid == 1'b0, "R9 rd_valid in reset", int'(rd_valid), 0);
        check(overflow == 1'b0, "R9 overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R9 rd_valid after reset", int'(rd_valid), 0);
        check(overflow == 1'b0, "R9 overflow after reset", int'(overflow), 0);

        // R2/R3: single straight track on row 40 -> frame row 33
        cur_req = "R2"; clear_pat(); add_track(40, 2, 8);
        b = bx_cnt; push_exp(33, b + 8'd2); play(40); scenario_end();

        // R1: array edges, one BX, ascending
        cur_req = "R1"; clear_pat(); add_track(3, 0, 8); add_track(127, 0, 8);
        b = bx_cnt; push_exp(0, b); push_exp(120, b); play(40); scenario_end();

        // R6: two distant tracks in one BX, ascending order
        cur_req = "R6"; clear_pat(); add_track(90, 1, 8); add_track(20, 1, 8);
        b = bx_cnt; push_exp(13, b + 8'd1); push_exp(83, b + 8'd1); play(40); scenario_end();

        // R4: two close tracks in one BX -> one report
        cur_req = "R4"; clear_pat(); add_track(40, 0, 8); add_track(45, 0, 8);
        b = bx_cnt; push_exp(33, b); play(40); scenario_end();

        // R2: only 6 active BX -> nothing
        cur_req = "R2"; clear_pat(); add_track(60, 0, 6);
        play(40); scenario_end();

        // R3: window with a gap -> oldest active BX reported
        cur_req = "R3"; clear_pat(); add_track(60, 0, 1); add_track(60, 2, 6);
        b = bx_cnt; push_exp(53, b); play(40); scenario_end();

        // R4: lower detection 3 BX earlier vetoes
        cur_req = "R4"; clear_pat(); add_track(40, 0, 8); add_track(47, 3, 8);
        b = bx_cnt; push_exp(33, b); play(40); scenario_end();

        // R4: lower detection 4 BX earlier no longer vetoes
        cur_req = "R4"; clear_pat(); add_track(40, 0, 8); add_track(47, 4, 8);
        b = bx_cnt; push_exp(33, b); push_exp(41, b + 8'd4); play(40); scenario_end();

        // R5: upper detection 2 BX earlier vetoes a later lower one
        cur_req = "R5"; clear_pat(); add_track(50, 0, 8); add_track(45, 2, 8);
        b = bx_cnt; push_exp(43, b); play(40); scenario_end();

        cur_req = "R8";
        check(overflow == 1'b0, "R8 no loss yet", int'(overflow), 0);

        // R8: FIFO full with reads held off
        drain_en = 1'b0;
        clear_pat();
        add_track(10, 0, 8); add_track(30, 0, 8); add_track(50, 0, 8);
        add_track(70, 0, 8); add_track(90, 0, 8);
        b = bx_cnt; play(40);
        check(overflow == 1'b1, "R8 overflow set", int'(overflow), 1);
        check(rd_valid == 1'b1, "R7 valid while holding", int'(rd_valid), 1);
        cur_req = "R7";
        push_exp(3, b); push_exp(23, b); push_exp(43, b); push_exp(63, b);
        drain_en = 1'b1;
        repeat (20) @(negedge clk);
        scenario_end();
        check(rd_valid == 1'b0, "R7 empty after drain", int'(rd_valid), 0);
        check(overflow == 1'b1, "R8 overflow sticky", int'(overflow), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule